// File: doc/BRIEF.md
# Streaming command frame receiver

This block sits behind a UART receiver and turns its byte stream back into command frames. Each received byte arrives with a one-cycle strobe. While idle, the block looks for the start byte 0xFE. It then collects a length byte, two command bytes, the number of payload bytes that the length gives, and a closing checksum byte. The payload goes into an internal buffer, and the consumer reads it through a combinational address/data port. The first command byte is decoded into a frame kind (from its high nibble) and a subsystem (from its low nibble).

A frame that passes both the length cap and the checksum raises `frm_valid` for one clock. In that same clock, the command bytes, the length and the decoded fields appear on held output registers. A frame with a bad length or a bad checksum is dropped. Its failure is reported on its own pulse output, and the parser goes back to looking for a start byte. Frames whose kind nibble is not recognised are still delivered, with a flag set, so that downstream logic can decide whether to use them.

Top module: `mt_frame_rx`

## Requirements
- R1: While looking for a frame, every accepted byte other than 0xFE is discarded without any output event. A valid frame that follows such bytes is decoded normally.
- R2: A frame is 0xFE, a length byte L, command byte 0, command byte 1, L payload bytes and a checksum byte. When the checksum is good, `frm_valid` is high for exactly the one clock that follows the edge at which the checksum byte is accepted. In that clock `frm_cmd0`, `frm_cmd1` and `frm_len` show the frame's values, and they hold until the next good frame.
- R3: A length byte greater than MAX_LEN (250) makes `err_len` pulse in the clock after the length byte. No frame is delivered, and the parser returns to looking for 0xFE. A length of exactly 250 is accepted.
- R4: The checksum is the XOR of the length byte, both command bytes and all payload bytes; the start byte is not included. On a mismatch, `err_fcs` pulses in the clock after the checksum byte, `frm_valid` stays low, and the held outputs keep their previous values.
- R5: A zero-length frame is legal. Its checksum byte comes directly after command byte 1.
- R6: After a good frame, `rd_data` equals payload byte number `rd_addr` (counting from 0) of that frame. This holds until payload bytes of a later frame begin to arrive.
- R7: `frm_kind` decodes the high nibble of `frm_cmd0`: 0x2 gives 0 (synchronous request), 0x4 gives 1 (asynchronous message), 0x6 gives 2 (synchronous response), and any other value gives 3 with `frm_unk_type` set to 1. A frame with an unknown kind is still delivered.
- R8: `frm_sub` decodes the low nibble of `frm_cmd0`: 0x1 gives 0 (system), 0x4 gives 1 (application framework), 0x5 gives 2 (device object), 0xF gives 3 (application configuration), and any other value gives 4.
- R9: Clocks in which `in_valid` is low change neither the parser state nor the outputs, so gaps between bytes have no effect on the result.
- R10: A synchronous reset clears `frm_valid`, `err_fcs`, `err_len` and the held frame outputs to zero (so the kind reads 3 with the flag set, and the subsystem reads 4). It also discards a partly received frame.
- R11: Once a frame has started, a 0xFE byte in any field is taken as that field's value and does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte strobe from the UART receiver |
| in_byte | input | 8 | Received byte |
| rd_addr | input | AW (8) | Payload buffer read index |
| frm_valid | output | 1 | One-clock pulse for a good frame |
| frm_cmd0 | output | 8 | Command byte 0 of the last good frame |
| frm_cmd1 | output | 8 | Command byte 1 of the last good frame |
| frm_len | output | 8 | Payload length of the last good frame |
| frm_kind | output | 2 | Decoded frame kind |
| frm_unk_type | output | 1 | Kind nibble not recognised |
| frm_sub | output | 3 | Decoded subsystem |
| rd_data | output | 8 | Payload byte at `rd_addr` |
| err_fcs | output | 1 | One-clock pulse on a checksum mismatch |
| err_len | output | 1 | One-clock pulse on a length above the cap |

## Verification
The assertions assume that `in_valid` and `in_byte` are known whenever reset is low, and that the consumer reads the payload before the next frame's data bytes arrive. The stimulus changes inputs only on falling edges and keeps the strobe clean. It issues payload reads only in idle clocks between frames, so every read falls inside the window that R6 promises. Streams include garbage between frames, gaps between bytes and a reset in the middle of a frame. An oversize length is followed only by bytes that are not 0xFE, so the intended resynchronisation point is unambiguous.

// File: rtl/mt_rx_pkg.sv
package mt_rx_pkg;

   typedef enum logic [2:0] {
      ST_HUNT,
      ST_LEN,
      ST_CMD0,
      ST_CMD1,
      ST_DATA,
      ST_FCS
   } rx_state_t;

   localparam logic [1:0] KIND_SREQ = 2'd0;
   localparam logic [1:0] KIND_AREQ = 2'd1;
   localparam logic [1:0] KIND_SRSP = 2'd2;
   localparam logic [1:0] KIND_UNK  = 2'd3;

   localparam logic [2:0] SUB_SYS   = 3'd0;
   localparam logic [2:0] SUB_AF    = 3'd1;
   localparam logic [2:0] SUB_ZDO   = 3'd2;
   localparam logic [2:0] SUB_APP   = 3'd3;
   localparam logic [2:0] SUB_OTHER = 3'd4;

   function automatic logic [1:0] kind_of(input logic [3:0] hi);
      case (hi)
         4'h2:    kind_of = KIND_SREQ;
         4'h4:    kind_of = KIND_AREQ;
         4'h6:    kind_of = KIND_SRSP;
         default: kind_of = KIND_UNK;
      endcase
   endfunction

   function automatic logic [2:0] sub_of(input logic [3:0] lo);
      case (lo)
         4'h1:    sub_of = SUB_SYS;
         4'h4:    sub_of = SUB_AF;
         4'h5:    sub_of = SUB_ZDO;
         4'hF:    sub_of = SUB_APP;
         default: sub_of = SUB_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/mt_rx_fsm.sv
module mt_rx_fsm
   import mt_rx_pkg::*;
#(
   parameter int          MAX_LEN  = 250,
   parameter logic [7:0]  SOF_BYTE = 8'hFE,
   parameter int          AW       = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   output logic          wr_en,
   output logic [AW-1:0] wr_idx,
   output logic          frame_ok,
   output logic          bad_fcs,
   output logic          bad_len,
   output logic [7:0]    hold_cmd0,
   output logic [7:0]    hold_cmd1,
   output logic [7:0]    hold_len
);

   rx_state_t     st;
   logic [7:0]    acc;
   logic [7:0]    remain;
   logic [AW-1:0] idx;
   logic [7:0]    cur_cmd0;
   logic [7:0]    cur_cmd1;
   logic [7:0]    cur_len;

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_HUNT;
         acc       <= '0;
         remain    <= '0;
         idx       <= '0;
         cur_cmd0  <= '0;
         cur_cmd1  <= '0;
         cur_len   <= '0;
         frame_ok  <= 1'b0;
         bad_fcs   <= 1'b0;
         bad_len   <= 1'b0;
         hold_cmd0 <= '0;
         hold_cmd1 <= '0;
         hold_len  <= '0;
      end else begin
         frame_ok <= 1'b0;
         bad_fcs  <= 1'b0;
         bad_len  <= 1'b0;
         if (in_valid) begin
            unique case (st)
               ST_HUNT: begin
                  if (in_byte == SOF_BYTE) st <= ST_LEN;
               end
               ST_LEN: begin
                  if (int'(in_byte) > MAX_LEN) begin
                     bad_len <= 1'b1;
                     st      <= ST_HUNT;
                  end else begin
                     cur_len <= in_byte;
                     remain  <= in_byte;
                     acc     <= in_byte;
                     idx     <= '0;
                     st      <= ST_CMD0;
                  end
               end
               ST_CMD0: begin
                  cur_cmd0 <= in_byte;
                  acc      <= acc ^ in_byte;
                  st       <= ST_CMD1;
               end
               ST_CMD1: begin
                  cur_cmd1 <= in_byte;
                  acc      <= acc ^ in_byte;
                  st       <= (remain == 8'd0) ? ST_FCS : ST_DATA;
               end
               ST_DATA: begin
                  acc    <= acc ^ in_byte;
                  idx    <= idx + 1'b1;
                  remain <= remain - 8'd1;
                  if (remain == 8'd1) st <= ST_FCS;
               end
               ST_FCS: begin
                  st <= ST_HUNT;
                  if (acc == in_byte) begin
                     frame_ok  <= 1'b1;
                     hold_cmd0 <= cur_cmd0;
                     hold_cmd1 <= cur_cmd1;
                     hold_len  <= cur_len;
                  end else begin
                     bad_fcs <= 1'b1;
                  end
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end

   assign wr_en  = in_valid && (st == ST_DATA);
   assign wr_idx = idx;

   // R2: a good frame is a lone pulse
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      frame_ok |=> !frame_ok);

   // R4: checksum failure and delivery never coincide
   a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(frame_ok && bad_fcs));

   // R3: a length error is caused by an oversize byte
   a_r3_len_cause: assert property (@(posedge clk) disable iff (rst)
      bad_len |-> ($past(in_valid) && (int'($past(in_byte)) > MAX_LEN)));

   // R3: delivered lengths respect the cap
   a_r3_len_cap: assert property (@(posedge clk) disable iff (rst)
      frame_ok |-> (int'(hold_len) <= MAX_LEN));

   // R9: no event follows a clock without a byte
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!frame_ok && !bad_fcs && !bad_len));

   // R9: held outputs change only on a byte clock
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(hold_cmd0) && $stable(hold_len));

   // R10: reset leaves no pulse behind
   a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (!frame_ok && !bad_fcs && !bad_len && hold_len == 8'd0));

endmodule

// File: rtl/mt_rx_buf.sv
module mt_rx_buf #(
   parameter int DEPTH    = 250,
   parameter int AW       = 8,
   parameter bit REG_READ = 1'b0
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [7:0]    wr_byte,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);

   logic [7:0] mem [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_byte;
   end

   generate
      if (REG_READ) begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[rd_addr];
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/mt_rx_decode.sv
module mt_rx_decode
   import mt_rx_pkg::*;
(
   input  logic [7:0] cmd0,
   output logic [1:0] kind,
   output logic       unk_type,
   output logic [2:0] sub
);

   always_comb begin
      kind     = kind_of(cmd0[7:4]);
      sub      = sub_of(cmd0[3:0]);
      unk_type = (kind == KIND_UNK);
   end

endmodule

// File: rtl/mt_frame_rx.sv
module mt_frame_rx
   import mt_rx_pkg::*;
#(
   parameter int         MAX_LEN  = 250,
   parameter logic [7:0] SOF_BYTE = 8'hFE,
   parameter bit         REG_READ = 1'b0,
   localparam int        AW       = $clog2(MAX_LEN)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   input  logic [AW-1:0] rd_addr,
   output logic          frm_valid,
   output logic [7:0]    frm_cmd0,
   output logic [7:0]    frm_cmd1,
   output logic [7:0]    frm_len,
   output logic [1:0]    frm_kind,
   output logic          frm_unk_type,
   output logic [2:0]    frm_sub,
   output logic [7:0]    rd_data,
   output logic          err_fcs,
   output logic          err_len
);

   generate
      if (MAX_LEN < 2 || MAX_LEN > 255) begin : g_bad_len
         $error("mt_frame_rx: MAX_LEN must lie in 2..255");
      end
   endgenerate

   logic          wr_en;
   logic [AW-1:0] wr_idx;

   mt_rx_fsm #(
      .MAX_LEN  (MAX_LEN),
      .SOF_BYTE (SOF_BYTE),
      .AW       (AW)
   ) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .frame_ok  (frm_valid),
      .bad_fcs   (err_fcs),
      .bad_len   (err_len),
      .hold_cmd0 (frm_cmd0),
      .hold_cmd1 (frm_cmd1),
      .hold_len  (frm_len)
   );

   mt_rx_buf #(
      .DEPTH    (MAX_LEN),
      .AW       (AW),
      .REG_READ (REG_READ)
   ) u_buf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_byte (in_byte),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   mt_rx_decode u_dec (
      .cmd0     (frm_cmd0),
      .kind     (frm_kind),
      .unk_type (frm_unk_type),
      .sub      (frm_sub)
   );

   // R7: request nibble maps to kind 0
   a_r7_sreq: assert property (@(posedge clk) disable iff (rst)
      (frm_valid && frm_cmd0[7:4] == 4'h2) |-> (frm_kind == KIND_SREQ));

   // R7: a recognised kind never carries the unknown flag
   a_r7_known_flag: assert property (@(posedge clk) disable iff (rst)
      (frm_valid && frm_kind != KIND_UNK) |-> !frm_unk_type);

   // R8: system subsystem nibble
   a_r8_sys: assert property (@(posedge clk) disable iff (rst)
      (frm_valid && frm_cmd0[3:0] == 4'h1) |-> (frm_sub == SUB_SYS));

   // R4: error pulses are mutually exclusive
   a_r4_one_error: assert property (@(posedge clk) disable iff (rst)
      !(err_fcs && err_len));

endmodule

// File: tb/mt_frame_rx_tb.sv
module mt_frame_rx_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic [7:0] rd_addr = 8'h00;
   logic       frm_valid;
   logic [7:0] frm_cmd0, frm_cmd1, frm_len;
   logic [1:0] frm_kind;
   logic       frm_unk_type;
   logic [2:0] frm_sub;
   logic [7:0] rd_data;
   logic       err_fcs, err_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   mt_frame_rx u_dut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_byte      (in_byte),
      .rd_addr      (rd_addr),
      .frm_valid    (frm_valid),
      .frm_cmd0     (frm_cmd0),
      .frm_cmd1     (frm_cmd1),
      .frm_len      (frm_len),
      .frm_kind     (frm_kind),
      .frm_unk_type (frm_unk_type),
      .frm_sub      (frm_sub),
      .rd_data      (rd_data),
      .err_fcs      (err_fcs),
      .err_len      (err_len)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // behavioural reference
   int         m_phase;
   int         m_left;
   logic [7:0] m_acc, m_len, m_c0, m_c1;
   logic [7:0] m_cur[$];
   logic       e_fv, e_ef, e_el;
   logic [7:0] e_c0, e_c1, e_len;
   logic [7:0] e_pl[$];

   function automatic int ref_kind(input logic [7:0] c);
      case (c[7:4])
         4'h2: return 0;
         4'h4: return 1;
         4'h6: return 2;
         default: return 3;
      endcase
   endfunction

   function automatic int ref_sub(input logic [7:0] c);
      case (c[3:0])
         4'h1: return 0;
         4'h4: return 1;
         4'h5: return 2;
         4'hF: return 3;
         default: return 4;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_phase = 0; m_left = 0; m_acc = 0; m_len = 0; m_c0 = 0; m_c1 = 0;
      m_cur.delete();
      e_fv = 0; e_ef = 0; e_el = 0; e_c0 = 0; e_c1 = 0; e_len = 0;
      e_pl.delete();
   endtask

   task automatic model_byte(input logic v, input logic [7:0] b);
      e_fv = 0; e_ef = 0; e_el = 0;
      if (v) begin
         case (m_phase)
            0: if (b == 8'hFE) m_phase = 1;
            1: if (int'(b) > 250) begin e_el = 1; m_phase = 0; end
               else begin
                  m_len = b; m_left = int'(b); m_acc = b; m_cur.delete(); m_phase = 2;
               end
            2: begin m_c0 = b; m_acc ^= b; m_phase = 3; end
            3: begin m_c1 = b; m_acc ^= b; m_phase = (m_left == 0) ? 5 : 4; end
            4: begin m_acc ^= b; m_cur.push_back(b); m_left--; if (m_left == 0) m_phase = 5; end
            default: begin
               m_phase = 0;
               if (m_acc == b) begin
                  e_fv = 1; e_c0 = m_c0; e_c1 = m_c1; e_len = m_len; e_pl = m_cur;
               end else e_ef = 1;
            end
         endcase
      end
   endtask

   task automatic compare_all();
      chk(frm_valid == e_fv, "R2", "frm_valid", int'(frm_valid), int'(e_fv));
      chk(err_fcs == e_ef, "R4", "err_fcs", int'(err_fcs), int'(e_ef));
      chk(err_len == e_el, "R3", "err_len", int'(err_len), int'(e_el));
      chk(frm_cmd0 == e_c0, "R2", "frm_cmd0", int'(frm_cmd0), int'(e_c0));
      chk(frm_cmd1 == e_c1, "R2", "frm_cmd1", int'(frm_cmd1), int'(e_c1));
      chk(frm_len == e_len, "R2", "frm_len", int'(frm_len), int'(e_len));
      chk(int'(frm_kind) == ref_kind(e_c0), "R7", "frm_kind", int'(frm_kind), ref_kind(e_c0));
      chk(frm_unk_type == (ref_kind(e_c0) == 3), "R7", "frm_unk_type",
          int'(frm_unk_type), int'(ref_kind(e_c0) == 3));
      chk(int'(frm_sub) == ref_sub(e_c0), "R8", "frm_sub", int'(frm_sub), ref_sub(e_c0));
   endtask

   task automatic step(input logic v, input logic [7:0] b);
      in_valid = v;
      in_byte  = b;
      model_byte(v, b);
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
      model_reset();
      @(negedge clk);
      compare_all();
      rst = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] c0, input logic [7:0] c1,
                             input logic [7:0] pl[$], input int gap, input bit corrupt);
      logic [7:0] bytes[$];
      logic [7:0] x;
      x = 8'(pl.size()) ^ c0 ^ c1;
      foreach (pl[i]) x ^= pl[i];
      if (corrupt) x ^= 8'h01;
      bytes.push_back(8'hFE);
      bytes.push_back(8'(pl.size()));
      bytes.push_back(c0);
      bytes.push_back(c1);
      foreach (pl[i]) bytes.push_back(pl[i]);
      bytes.push_back(x);
      foreach (bytes[i]) begin
         step(1'b1, bytes[i]);
         for (int g = 0; g < gap; g++) step(1'b0, 8'h00);
      end
   endtask

   // R6: read back the last good payload in idle clocks
   task automatic check_payload();
      foreach (e_pl[i]) begin
         rd_addr = 8'(i);
         step(1'b0, 8'h00);
         chk(rd_data == e_pl[i], "R6", "rd_data", int'(rd_data), int'(e_pl[i]));
      end
   endtask

   task automatic send_raw(input logic [7:0] bs[$]);
      foreach (bs[i]) step(1'b1, bs[i]);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] pl[$];
      @(negedge clk);
      // R10: reset state
      do_reset();
      repeat (3) step(1'b0, 8'h00);

      // R1: garbage before a frame, then SREQ/SYS with payload (R7, R8)
      send_raw('{8'h00, 8'h55, 8'hFD, 8'h21});
      send_frame(8'h21, 8'h02, '{8'h11, 8'h22, 8'h33}, 0, 1'b0);
      check_payload();

      // R5: zero-length AREQ to the device object subsystem
      pl.delete();
      send_frame(8'h45, 8'hC0, pl, 0, 1'b0);
      step(1'b0, 8'h00);

      // R4: corrupted checksum, then a good frame
      send_frame(8'h24, 8'h00, '{8'hA0, 8'hA1}, 0, 1'b1);
      send_frame(8'h61, 8'h01, '{8'h7E}, 0, 1'b0);
      check_payload();

      // R3: oversize length, rest hunted away
      send_raw('{8'hFE, 8'hFB, 8'h21, 8'h01, 8'h10, 8'h20});
      // R3: maximum length accepted
      pl.delete();
      for (int i = 0; i < 250; i++) pl.push_back(8'((i * 7 + 3) & 8'hFF) == 8'hFE ? 8'h00 : 8'((i * 7 + 3) & 8'hFF));
      send_frame(8'h2F, 8'h08, pl, 0, 1'b0);
      check_payload();

      // R9: gaps between bytes, SRSP on AF
      send_frame(8'h64, 8'h05, '{8'h01, 8'h02, 8'h03, 8'h04}, 2, 1'b0);
      check_payload();

      // R7/R8: unknown kind and unknown subsystem still delivered
      send_frame(8'h8F, 8'h10, '{8'h09}, 0, 1'b0);
      send_frame(8'h67, 8'h10, '{8'h0A}, 0, 1'b0);
      send_frame(8'h41, 8'h80, '{8'h00}, 1, 1'b0);

      // R11: start byte inside fields is data
      send_frame(8'h25, 8'hFE, '{8'hFE, 8'h05, 8'hFE}, 0, 1'b0);
      check_payload();

      // R10: reset mid-frame discards it
      send_raw('{8'hFE, 8'h03, 8'h21, 8'h01});
      do_reset();
      send_raw('{8'h10, 8'h20, 8'h30, 8'h00});
      send_frame(8'h21, 8'h01, pl[0:1], 0, 1'b0);
      check_payload();
      repeat (3) step(1'b0, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule